// File: doc/BRIEF.md
# Count/Compare Interval Timer

This block is a free-running cycle counter paired with a compare register. The counter advances by one on every tick-enable pulse; the nominal tick rate is 100 MHz, one step per 10 ns. When the counter steps or is loaded into equality with the compare value, the block raises a timer interrupt. The interrupt stays raised until software acknowledges it by writing the compare register.

Software reaches both values through a small write/read port. A freeze input stops the counter and suppresses new matches. The interrupt is steered at run time onto one of eight output lines by a 3-bit line-select field. A revision strap decides whether a match also sets a sticky timer-pending status bit. With the strap clear, that bit is left alone.

Top module: `interval_timer`

## Requirements
- R1: After reset, the counter and compare values read 0, `timer_pending` is 0 and `irq_out` is all zero.
- R2: While `freeze` is low, each cycle with `tick_en` high adds one to the counter, modulo 2^32, so 0xFFFFFFFF steps to 0x00000000.
- R3: While `freeze` is high, ticks leave the counter unchanged and no new interrupt is raised.
- R4: A write with `wr_sel`=0 loads `wr_data` into the counter and takes priority over a tick in the same cycle. Counting then continues from the loaded value. If the loaded value equals the compare value, it counts as a match.
- R5: When the counter becomes equal to the compare value, through a tick or a load, the interrupt is active from the first cycle in which the counter reads the equal value. It stays active through later ticks until the compare register is written.
- R6: While the interrupt is active, `irq_out` has exactly bit `line_sel` set, following `line_sel` as it changes. While the interrupt is inactive, `irq_out` is 0.
- R7: With `rev2_mode` high, a match sets `timer_pending`. With `rev2_mode` low, a match leaves `timer_pending` at 0 while still driving `irq_out`.
- R8: A write with `wr_sel`=1 loads the compare value, clears the interrupt, and clears `timer_pending` when `rev2_mode` is high. It wins over a match occurring in the same cycle.
- R9: A match fires only on a transition into equality. A counter held equal under `freeze`, or a compare write equal to the present count, does not raise the interrupt again.
- R10: `rd_data` returns the live counter when `rd_sel`=0 and the compare value when `rd_sel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One counter step per high cycle |
| freeze | input | 1 | Holds the counter and blocks matches |
| line_sel | input | 3 | Output line for the interrupt |
| rev2_mode | input | 1 | Enables the sticky pending bit |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = counter, 1 = compare |
| wr_data | input | 32 | Write value |
| rd_sel | input | 1 | 0 = counter, 1 = compare |
| rd_data | output | 32 | Selected register value |
| irq_out | output | 8 | Interrupt line vector |
| timer_pending | output | 1 | Sticky timer-pending status |

## Verification
On every cycle, the assertions check several properties. The counter moves only by a single step or a load, and never moves while frozen. `irq_out` is at most one-hot. An active interrupt persists until a compare write, and a compare write always leaves it cleared. The pending bit rises only when the strap is set. Only the bench scenarios can show the exact cycle at which a match appears, wrap-around, and the absence of retriggering after an acknowledge with the count held equal. The same holds for the priority of a compare write over a coincident match, and for routing to a newly selected line.

// File: rtl/timer_pkg.sv
package timer_pkg;
    localparam int TMR_W   = 32;
    localparam int N_LINES = 8;

    typedef enum logic {
        SEL_COUNT   = 1'b0,
        SEL_COMPARE = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/timer_counter.sv
module timer_counter #(
    parameter int W = timer_pkg::TMR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         freeze,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count_q,
    output logic [W-1:0] count_d,
    output logic         count_moved
);
    typedef struct packed {
        logic [W-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       step;

    always_comb begin
        st_d        = st_q;
        step        = tick_en && !freeze;
        count_moved = 1'b0;
        if (load_en) begin
            st_d.count  = load_val;
            count_moved = 1'b1;
        end else if (step) begin
            st_d.count  = st_q.count + W'(1);
            count_moved = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_q = st_q.count;
    assign count_d = st_d.count;

    // R3
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !load_en) |=> $stable(count_q));

    // R2
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && tick_en && !freeze) |=> (count_q == $past(count_q) + W'(1)));

    // R4
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (count_q == $past(load_val)));
endmodule

// File: rtl/timer_match.sv
module timer_match #(
    parameter int W = timer_pkg::TMR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rev2_mode,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_val,
    input  logic [W-1:0] count_d,
    input  logic         count_moved,
    output logic [W-1:0] compare_q,
    output logic         irq_active,
    output logic         pending
);
    typedef struct packed {
        logic [W-1:0] compare;
        logic         active;
        logic         pend;
    } match_state_t;

    match_state_t st_d, st_q;
    logic         hit;

    always_comb begin
        st_d = st_q;
        hit  = count_moved && (count_d == st_q.compare);
        if (cmp_wr) begin
            st_d.compare = cmp_val;
            st_d.active  = 1'b0;
            if (rev2_mode) st_d.pend = 1'b0;
        end else if (hit) begin
            st_d.active = 1'b1;
            if (rev2_mode) st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign compare_q  = st_q.compare;
    assign irq_active = st_q.active;
    assign pending    = st_q.pend;

    // R5
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_active && !cmp_wr) |=> irq_active);

    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> !irq_active);

    // R7
    pend_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(rev2_mode));

    // R9
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_active && !count_moved) |=> !irq_active);
endmodule

// File: rtl/timer_irq_route.sv
module timer_irq_route #(
    parameter int LINES = timer_pkg::N_LINES,
    localparam int SW   = $clog2(LINES)
) (
    input  logic             active,
    input  logic [SW-1:0]    line_sel,
    output logic [LINES-1:0] irq_out
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign irq_out[i] = active && (line_sel == SW'(i));
    end

    // R6
    always_comb begin
        onehot_line_chk: assert ($onehot0(irq_out));
    end
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int W     = timer_pkg::TMR_W,
    parameter int LINES = timer_pkg::N_LINES,
    localparam int SW   = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             freeze,
    input  logic [SW-1:0]    line_sel,
    input  logic             rev2_mode,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [W-1:0]     wr_data,
    input  logic             rd_sel,
    output logic [W-1:0]     rd_data,
    output logic [LINES-1:0] irq_out,
    output logic             timer_pending
);
    import timer_pkg::*;

    logic [W-1:0] count_q, count_d, compare_q;
    logic         count_moved, irq_active, cnt_wr, cmp_wr;

    assign cnt_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_COUNT);
    assign cmp_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_COMPARE);

    timer_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze(freeze),
        .load_en(cnt_wr), .load_val(wr_data),
        .count_q(count_q), .count_d(count_d), .count_moved(count_moved)
    );

    timer_match #(.W(W)) u_match (
        .clk(clk), .rst_n(rst_n), .rev2_mode(rev2_mode),
        .cmp_wr(cmp_wr), .cmp_val(wr_data),
        .count_d(count_d), .count_moved(count_moved),
        .compare_q(compare_q), .irq_active(irq_active), .pending(timer_pending)
    );

    timer_irq_route #(.LINES(LINES)) u_route (
        .active(irq_active), .line_sel(line_sel), .irq_out(irq_out)
    );

    assign rd_data = (reg_sel_e'(rd_sel) == SEL_COMPARE) ? compare_q : count_q;

    // R10
    read_mux_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel && $stable(rd_sel) && !$past(cmp_wr)) |-> $stable(rd_data));
endmodule

// File: tb/interval_timer_tb_top.sv
module interval_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0, freeze = 1'b0, rev2_mode = 1'b0;
    logic [2:0]  line_sel = 3'd0;
    logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [7:0]  irq_out;
    logic        timer_pending;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    interval_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze(freeze),
        .line_sel(line_sel), .rev2_mode(rev2_mode), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .irq_out(irq_out), .timer_pending(timer_pending)
    );

    // load value, tick count, expected counter afterwards (R2, R4)
    localparam logic [95:0] VEC [5] = '{
        {32'h0000_0000, 32'd5, 32'h0000_0005},
        {32'h0000_1234, 32'd1, 32'h0000_1235},
        {32'hFFFF_FFFE, 32'd3, 32'h0000_0001},
        {32'h7FFF_FFFF, 32'd2, 32'h8000_0001},
        {32'hDEAD_0000, 32'd0, 32'hDEAD_0000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic rd_count(output logic [31:0] v);
        rd_sel = 1'b0; #1 v = rd_data;
    endtask

    initial begin
        logic [31:0] v;
        #3000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        check("R1 count", rd_data, 32'h0);
        rd_sel = 1'b1; #1 check("R1 compare", rd_data, 32'h0);
        check("R1 irq", {24'h0, irq_out}, 32'h0);
        check("R1 pending", {31'h0, timer_pending}, 32'h0);
        rst_n = 1'b1;
        rd_sel = 1'b0;

        // keep compare away from table values
        wr(1'b1, 32'h5555_5555);
        for (int k = 0; k < 5; k++) begin
            wr(1'b0, VEC[k][95:64]);
            ticks(int'(VEC[k][63:32]));
            rd_count(v);
            check($sformatf("R2 R4 vector %0d", k), v, VEC[k][31:0]);
        end
        check("R10 no irq from vectors", {24'h0, irq_out}, 32'h0);

        // R4: write beats a simultaneous tick
        @(negedge clk);
        tick_en = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'd77;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0;
        rd_count(v); check("R4 write over tick", v, 32'd77);

        // R5 R6 R7: match with strap set
        rev2_mode = 1'b1; line_sel = 3'd3;
        wr(1'b1, 32'd10);
        rd_sel = 1'b1; #1 check("R10 compare read", rd_data, 32'd10); rd_sel = 1'b0;
        wr(1'b0, 32'd8);
        ticks(1);
        check("R5 not yet", {24'h0, irq_out}, 32'h0);
        ticks(1);
        check("R5 R6 match line 3", {24'h0, irq_out}, 32'h08);
        check("R7 pending set", {31'h0, timer_pending}, 32'h1);
        line_sel = 3'd7; #1;
        check("R6 line 7", {24'h0, irq_out}, 32'h80);
        ticks(3);
        check("R5 sticky", {24'h0, irq_out}, 32'h80);
        rd_count(v); check("R10 live count", v, 32'd13);
        wr(1'b1, 32'd100);
        check("R8 ack irq", {24'h0, irq_out}, 32'h0);
        check("R8 ack pending", {31'h0, timer_pending}, 32'h0);

        // R3 R9: held equal after ack does not retrigger
        line_sel = 3'd0;
        wr(1'b1, 32'd20);
        wr(1'b0, 32'd19);
        ticks(1);
        check("R9 match", {24'h0, irq_out}, 32'h01);
        freeze = 1'b1;
        wr(1'b1, 32'd20);
        ticks(4);
        check("R9 no retrigger", {24'h0, irq_out}, 32'h0);
        rd_count(v); check("R3 frozen count", v, 32'd20);

        // R3: frozen count cannot reach compare
        wr(1'b1, 32'd30);
        wr(1'b0, 32'd29);
        ticks(2);
        rd_count(v); check("R3 hold", v, 32'd29);
        check("R3 no match", {24'h0, irq_out}, 32'h0);
        freeze = 1'b0;

        // R8: compare write wins over coincident match
        wr(1'b1, 32'd40);
        wr(1'b0, 32'd39);
        @(negedge clk);
        tick_en = 1'b1; wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'd40;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0;
        rd_count(v); check("R8 count reached", v, 32'd40);
        check("R8 write wins", {24'h0, irq_out}, 32'h0);
        check("R8 pending stays", {31'h0, timer_pending}, 32'h0);

        // R7: strap clear leaves pending alone
        rev2_mode = 1'b0; line_sel = 3'd5;
        wr(1'b1, 32'd50);
        wr(1'b0, 32'd49);
        ticks(1);
        check("R7 irq without strap", {24'h0, irq_out}, 32'h20);
        check("R7 pending untouched", {31'h0, timer_pending}, 32'h0);

        // R4: load equal to compare is a match
        wr(1'b1, 32'd60);
        check("R8 ack strap clear", {24'h0, irq_out}, 32'h0);
        wr(1'b0, 32'd60);
        check("R4 load match", {24'h0, irq_out}, 32'h20);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule